// File: doc/BRIEF.md
# Timestamp Counter with Snapshot Read

This block keeps a free-running time of day as a seconds word and a nanoseconds word. The counter lives in a dedicated timer clock domain and moves forward by a fixed step on every timer clock edge. When the nanoseconds field reaches its last value before one full second, it returns to zero and the seconds word goes up by one on that same edge. A processor reads the time through a small memory-mapped slave port that runs on its own bus clock. That bus clock is asynchronous to the timer clock.

A two-word read must give a coherent timestamp even though the words arrive one after the other. Reading the seconds word therefore starts a toggle handshake into the timer domain. There, seconds and nanoseconds are captured together on one edge, and an acknowledge toggle travels back. The slave keeps wait-request asserted until that acknowledge arrives. It then returns the captured seconds and keeps the matching nanoseconds for the next nanoseconds read. With the default parameters, the step is 8 ns and one second spans 1,000,000,000 ns.

Top module: `tod_snap_counter`

## Requirements
- R1: On every timer clock edge out of reset the nanoseconds field grows by NS_STEP; it is always a multiple of NS_STEP and below NS_PER_SEC.
- R2: When nanoseconds equals NS_PER_SEC - NS_STEP, the next timer edge sets it to 0 and adds one to seconds; seconds changes on no other edge.
- R3: A read at word address 5 (seconds) captures seconds and nanoseconds on one timer edge. The time they form (seconds*NS_PER_SEC + nanoseconds) lies between the counter value when the read began and its value when the read completed.
- R4: During a seconds read, wait-request stays high until the capture acknowledge has crossed back, which takes at least 3 bus cycles. Read data is valid in the first cycle with wait-request low.
- R5: A read at word address 6 (nanoseconds) completes with wait-request low in the same cycle. It returns, zero-extended, the nanoseconds captured with the most recent seconds read.
- R6: A nanoseconds read starts no capture: repeated nanoseconds reads with no seconds read in between return the same value.
- R7: A read at any word address other than 5 or 6 returns 0 with wait-request low.
- R8: Writes to any address complete with wait-request low and change neither the counter nor the held snapshot.
- R9: Each domain has an active-high synchronous reset. After reset the counter restarts at 0, the snapshot reads 0 and wait-request is low.
- R10: Timestamps from successive seconds reads never go backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmrClk | input | 1 | Timer clock (125 MHz nominal) |
| tmrRst | input | 1 | Synchronous active-high reset, timer domain |
| busClk | input | 1 | Bus clock (100 MHz nominal) |
| busRst | input | 1 | Synchronous active-high reset, bus domain |
| busAddr | input | ADDR_W (3) | Word address of the access |
| busRead | input | 1 | Read strobe, held until wait-request is low |
| busWrite | input | 1 | Write strobe; writes have no effect and the port carries no write data |
| busRdData | output | DATA_W (32) | Read data |
| busWaitReq | output | 1 | High while a seconds read waits for its capture |

## Verification
The bench reads seconds/nanoseconds pairs at random gaps between 0 and 30 bus cycles. These land on every phase relation of the two clocks and span many second rollovers, because the bench uses a short second. The bench tracks the counter with its own tick count. A capture taken from the wrong edge, a rollover that skips the seconds carry, or a result handed back before the acknowledge arrives all leave the timestamp outside the read's time window. Mixed in at random are extra nanoseconds reads, reads of unmapped addresses and writes. These separate a correct held snapshot from a fresh capture, stale data or leftover data. Directed reads cover the state right after reset, and back-to-back seconds reads check monotonicity.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // word addresses decoded by the bus slave
  localparam int unsigned SEC_WORD = 5;
  localparam int unsigned NS_WORD  = 6;

  // bus-side read sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } busState_e;

  // strobes from the bus control to the timer datapath
  typedef struct packed {
    logic reqTgl;
  } snapCtl_t;
endpackage

// File: rtl/tod_sync2.sv
module tod_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic metaQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      metaQ <= 1'b0;
      dout  <= 1'b0;
    end else begin
      metaQ <= din;
      dout  <= metaQ;
    end
  end
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int unsigned NS_PER_SEC = 1000000000,
  parameter int unsigned NS_STEP    = 8,
  parameter int unsigned SEC_W      = 32,
  localparam int unsigned NS_W      = $clog2(NS_PER_SEC + 1)
) (
  input  logic             tmrClk,
  input  logic             tmrRst,
  input  snapCtl_t         snapCtl,
  output logic             ackTgl,
  output logic [SEC_W-1:0] capSec,
  output logic [NS_W-1:0]  capNs
);
  localparam logic [NS_W-1:0] NS_INC  = NS_W'(NS_STEP);
  localparam logic [NS_W-1:0] NS_LAST = NS_W'(NS_PER_SEC - NS_STEP);

  logic [NS_W-1:0]  nsCnt;
  logic [SEC_W-1:0] secCnt;
  logic             reqSeen;
  logic             capStrobe;

  // free-running time of day
  always_ff @(posedge tmrClk) begin
    if (tmrRst) begin
      nsCnt  <= '0;
      secCnt <= '0;
    end else if (nsCnt == NS_LAST) begin
      nsCnt  <= '0;
      secCnt <= secCnt + 1'b1;
    end else begin
      nsCnt <= nsCnt + NS_INC;
    end
  end

  tod_sync2 u_reqSync (
    .clk  (tmrClk),
    .rst  (tmrRst),
    .din  (snapCtl.reqTgl),
    .dout (reqSeen)
  );

  // a new request is pending while the synchronized toggle differs from the ack
  assign capStrobe = reqSeen != ackTgl;

  always_ff @(posedge tmrClk) begin
    if (tmrRst) begin
      ackTgl <= 1'b0;
      capSec <= '0;
      capNs  <= '0;
    end else if (capStrobe) begin
      ackTgl <= reqSeen;
      capSec <= secCnt;
      capNs  <= nsCnt;
    end
  end

  // R1
  ns_range_chk: assert property (@(posedge tmrClk) disable iff (tmrRst)
    (64'(nsCnt) < 64'(NS_PER_SEC)) && ((64'(nsCnt) % 64'(NS_STEP)) == 64'd0));

  // R1
  ns_step_chk: assert property (@(posedge tmrClk) disable iff (tmrRst)
    (nsCnt != '0) |-> (nsCnt == $past(nsCnt) + NS_INC));

  // R2
  sec_carry_chk: assert property (@(posedge tmrClk) disable iff (tmrRst)
    !$stable(secCnt) |-> (nsCnt == '0 && secCnt == $past(secCnt) + 1'b1));

  // R3
  cap_hold_chk: assert property (@(posedge tmrClk) disable iff (tmrRst)
    $stable(ackTgl) |-> ($stable(capSec) && $stable(capNs)));
endmodule

// File: rtl/tod_control.sv
module tod_control
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned NS_W   = 30
) (
  input  logic              busClk,
  input  logic              busRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  output logic [DATA_W-1:0] busRdData,
  output logic              busWaitReq,
  output snapCtl_t          snapCtl,
  input  logic              ackTgl,
  input  logic [SEC_W-1:0]  capSec,
  input  logic [NS_W-1:0]   capNs
);
  localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(SEC_WORD);
  localparam logic [ADDR_W-1:0] NS_ADDR  = ADDR_W'(NS_WORD);

  busState_e        stateQ;
  logic             reqTgl;
  logic             ackSeen;
  logic             rdEn;
  logic             secHit;
  logic [SEC_W-1:0] snapSec;
  logic [NS_W-1:0]  snapNs;

  assign rdEn   = busRead && !busWrite;
  assign secHit = rdEn && (busAddr == SEC_ADDR);

  tod_sync2 u_ackSync (
    .clk  (busClk),
    .rst  (busRst),
    .din  (ackTgl),
    .dout (ackSeen)
  );

  always_ff @(posedge busClk) begin
    if (busRst) begin
      stateQ  <= ST_IDLE;
      reqTgl  <= 1'b0;
      snapSec <= '0;
      snapNs  <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (secHit) begin
            reqTgl <= ~reqTgl;
            stateQ <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (ackSeen == reqTgl) begin
            snapSec <= capSec;
            snapNs  <= capNs;
            stateQ  <= ST_DONE;
          end
        end
        ST_DONE: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign snapCtl.reqTgl = reqTgl;
  assign busWaitReq     = secHit && (stateQ != ST_DONE);

  always_comb begin
    busRdData = '0;
    if (rdEn) begin
      if (busAddr == SEC_ADDR)     busRdData = DATA_W'(snapSec);
      else if (busAddr == NS_ADDR) busRdData = DATA_W'(snapNs);
    end
  end

  // R4
  done_after_busy_chk: assert property (@(posedge busClk) disable iff (busRst)
    (stateQ == ST_DONE) |-> ($past(stateQ) == ST_BUSY));

  // R6
  req_idle_chk: assert property (@(posedge busClk) disable iff (busRst)
    (reqTgl != $past(reqTgl)) |-> ($past(stateQ) == ST_IDLE && $past(secHit)));

  // R5
  snap_hold_chk: assert property (@(posedge busClk) disable iff (busRst)
    (stateQ != ST_DONE) |-> ($stable(snapNs) && $stable(snapSec)));

  // R7
  unmapped_zero_chk: assert property (@(posedge busClk) disable iff (busRst)
    (busRead && busAddr != SEC_ADDR && busAddr != NS_ADDR) |-> (busRdData == '0 && !busWaitReq));
endmodule

// File: rtl/tod_snap_counter.sv
module tod_snap_counter
  import tod_pkg::*;
#(
  parameter int unsigned NS_PER_SEC = 1000000000,
  parameter int unsigned NS_STEP    = 8,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              tmrClk,
  input  logic              tmrRst,
  input  logic              busClk,
  input  logic              busRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  output logic [DATA_W-1:0] busRdData,
  output logic              busWaitReq
);
  localparam int unsigned NS_W  = $clog2(NS_PER_SEC + 1);
  localparam int unsigned SEC_W = DATA_W;

  snapCtl_t         snapCtl;
  logic             ackTgl;
  logic [SEC_W-1:0] capSec;
  logic [NS_W-1:0]  capNs;

  tod_datapath #(
    .NS_PER_SEC (NS_PER_SEC),
    .NS_STEP    (NS_STEP),
    .SEC_W      (SEC_W)
  ) u_datapath (
    .tmrClk  (tmrClk),
    .tmrRst  (tmrRst),
    .snapCtl (snapCtl),
    .ackTgl  (ackTgl),
    .capSec  (capSec),
    .capNs   (capNs)
  );

  tod_control #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEC_W  (SEC_W),
    .NS_W   (NS_W)
  ) u_control (
    .busClk     (busClk),
    .busRst     (busRst),
    .busAddr    (busAddr),
    .busRead    (busRead),
    .busWrite   (busWrite),
    .busRdData  (busRdData),
    .busWaitReq (busWaitReq),
    .snapCtl    (snapCtl),
    .ackTgl     (ackTgl),
    .capSec     (capSec),
    .capNs      (capNs)
  );
endmodule

// File: tb/tod_snap_counter_tb.sv
module tod_snap_counter_tb;
  localparam int BUS_PERIOD = 10;
  localparam int TMR_PERIOD = 8;
  localparam int NSPS       = 400;
  localparam int STEP       = 8;
  localparam int MIN_WAIT   = 3;
  localparam int MAX_WAIT   = 12;

  logic        tmrClk = 1'b0;
  logic        busClk = 1'b0;
  logic        tmrRst = 1'b1;
  logic        busRst = 1'b1;
  logic [2:0]  busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busRdData;
  logic        busWaitReq;

  longint tmrTicks = 0;
  int     total = 0;
  int     bad = 0;
  bit     finished = 1'b0;

  // bench model state
  longint pendSec, pendT0, pendT1, prevVal, prevSec;
  bit     nsKnown;
  longint lastNs;

  tod_snap_counter #(
    .NS_PER_SEC (NSPS),
    .NS_STEP    (STEP),
    .ADDR_W     (3),
    .DATA_W     (32)
  ) u_dut (
    .tmrClk     (tmrClk),
    .tmrRst     (tmrRst),
    .busClk     (busClk),
    .busRst     (busRst),
    .busAddr    (busAddr),
    .busRead    (busRead),
    .busWrite   (busWrite),
    .busRdData  (busRdData),
    .busWaitReq (busWaitReq)
  );

  always #(TMR_PERIOD / 2) tmrClk = ~tmrClk;
  always #(BUS_PERIOD / 2) busClk = ~busClk;

  always @(posedge tmrClk) begin
    if (tmrRst) tmrTicks <= 0;
    else        tmrTicks <= tmrTicks + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint tsOf(input longint s, input longint ns);
    return s * NSPS + ns;
  endfunction

  task automatic busAccess(input logic [2:0] a, input bit wr, output logic [31:0] d,
                           output int waits, output longint t0, output longint t1);
    @(negedge busClk);
    busAddr  = a;
    busRead  = !wr;
    busWrite = wr;
    #1;
    t0 = tmrTicks;
    waits = 0;
    while (busWaitReq && waits < 40) begin
      @(negedge busClk);
      #1;
      waits++;
    end
    d  = busRdData;
    t1 = tmrTicks;
    @(negedge busClk);
    busRead  = 1'b0;
    busWrite = 1'b0;
    busAddr  = '0;
  endtask

  task automatic secRead();
    logic [31:0] d; int w; longint t0, t1;
    busAccess(3'd5, 1'b0, d, w, t0, t1);
    // R4: wait-request held until the acknowledge returns
    check(w >= MIN_WAIT && w <= MAX_WAIT, "R4 seconds read wait cycles", w, MIN_WAIT);
    // R10: seconds never go backwards
    check(longint'(d) >= prevSec, "R10 seconds monotonic", longint'(d), prevSec);
    prevSec = longint'(d);
    pendSec = longint'(d);
    pendT0  = t0;
    pendT1  = t1;
    nsKnown = 1'b0;
  endtask

  task automatic nsRead();
    logic [31:0] d; int w; longint t0, t1, v;
    busAccess(3'd6, 1'b0, d, w, t0, t1);
    check(w == 0, "R5 nanoseconds read has no wait", w, 0);
    if (!nsKnown) begin
      // R1: field within range and aligned to the step
      check(longint'(d) < NSPS && (longint'(d) % STEP) == 0, "R1 nanoseconds range and step",
            longint'(d), 0);
      v = tsOf(pendSec, longint'(d));
      // R2 R3: combined value within the read window
      check(v >= pendT0 * STEP && v <= pendT1 * STEP, "R3 R2 coherent snapshot in window",
            v, pendT0 * STEP);
      check(v >= prevVal, "R10 timestamp monotonic", v, prevVal);
      prevVal = v;
      lastNs  = longint'(d);
      nsKnown = 1'b1;
    end else begin
      check(longint'(d) == lastNs, "R6 repeated nanoseconds read unchanged", longint'(d), lastNs);
    end
  endtask

  task automatic unmappedRead(input logic [2:0] a);
    logic [31:0] d; int w; longint t0, t1;
    busAccess(a, 1'b0, d, w, t0, t1);
    check(d == 32'd0 && w == 0, "R7 unmapped read is zero without wait", longint'(d), 0);
  endtask

  task automatic writeAcc(input logic [2:0] a);
    logic [31:0] d; int w; longint t0, t1;
    busAccess(a, 1'b1, d, w, t0, t1);
    check(w == 0, "R8 write completes without wait", w, 0);
  endtask

  initial begin
    repeat (150000) @(posedge busClk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    seedv   = $urandom(32'd2024);
    prevVal = 0;
    prevSec = 0;
    pendSec = 0;
    pendT0  = 0;
    pendT1  = 0;
    nsKnown = 1'b1;
    lastNs  = 0;

    repeat (6) @(negedge busClk);
    #2;
    tmrRst = 1'b0;
    busRst = 1'b0;

    // R9: reset state
    @(negedge busClk);
    #1;
    check(busWaitReq == 1'b0, "R9 wait-request low after reset", busWaitReq, 0);
    nsRead();
    check(lastNs == 0, "R9 snapshot zero after reset", lastNs, 0);

    // directed: coherent pair right after reset
    secRead();
    check(pendSec == 0, "R9 counter restarted at zero", pendSec, 0);
    nsRead();
    nsRead();

    // directed: all unmapped addresses
    for (int a = 0; a < 8; a++) begin
      if (a != 5 && a != 6) unmappedRead(3'(a));
    end

    // directed: writes leave the snapshot alone
    writeAcc(3'd5);
    writeAcc(3'd6);
    nsRead();

    // directed: back-to-back seconds reads
    for (int i = 0; i < 4; i++) begin
      secRead();
      nsRead();
    end

    // directed: walk across several second boundaries
    for (int i = 0; i < 30; i++) begin
      repeat (i % 7) @(negedge busClk);
      secRead();
      nsRead();
    end

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0, 1: begin secRead(); nsRead(); end
        2:    nsRead();
        3: begin
          int a;
          a = $urandom_range(0, 5);
          if (a == 5) a = 7;
          unmappedRead(3'(a));
        end
        4: begin
          writeAcc(3'($urandom_range(0, 7)));
          nsRead();
        end
        default: repeat ($urandom_range(0, 30)) @(negedge busClk);
      endcase
    end

    // final pair confirms rollovers carried into seconds
    secRead();
    nsRead();
    check(pendSec > 0, "R2 seconds advanced across rollovers", pendSec, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule